// File: doc/BRIEF.md
# Packet to Memory-Mapped Transaction Engine

This block turns framed request packets into 32-bit accesses on a simple memory-mapped master port. It then returns a framed response packet. Requests arrive one byte per cycle on a valid/ready stream with start and end markers. Each request opens with an eight-byte header. The header carries an opcode, one byte that is ignored, a byte count sent most significant byte first, and a byte address sent most significant byte first. For writes, the data words follow the header, least significant byte first within each word.

The engine buffers the whole request before it starts any bus cycle. This lets it reject a malformed request without touching the bus. It then performs one bus access per word, either at a fixed address or at addresses that step by four. Write requests end with a four-byte acknowledgement. Read requests return only the data bytes. Responses leave on a byte stream with start and end markers that honours backpressure.

Top module: `pkt_mm_engine`

## Requirements
- R1: Header byte 0 is the opcode: 0x00 write, 0x04 incrementing write, 0x10 read, 0x14 incrementing read. Byte 1 is ignored. Bytes 2..3 are the byte count and bytes 4..7 the address, both most significant byte first. The first bus access of a request uses that address.
- R2: For a write, packet byte 8+4k+j drives bits [8j+7:8j] of the writedata of the k-th write access.
- R3: A request makes count/4 bus accesses. With the incrementing opcodes the address grows by 4 per access. With the other two opcodes every access uses the header address.
- R4: After the last write access is accepted, the response is 4 bytes: opcode XOR 0x80, 0x00, count[15:8], count[7:0]. The start marker is on the first byte and the end marker on the last.
- R5: A read response is only the read words, each sent least significant byte first, in access order. The start marker is on the first byte and the end marker on the last byte of the last word.
- R6: A request is rejected with no bus access when any of the following holds:
  - the opcode is not one of the four codes;
  - the count is 0, not a multiple of 4, or above 4*MAX_WORDS;
  - a read packet is not exactly 8 bytes long;
  - a write packet is not exactly 8+count bytes long.
  A rejected request gets the 4-byte response opcode XOR 0x80, 0x00, 0x00, 0x00.
- R7: While waitrequest is high during an access, address, read, write and writedata hold their values. Read and write are never high together.
- R8: While out_valid_o is high and out_ready_i is low, the output byte and its markers hold.
- R9: in_ready_o is low whenever a bus access is in progress. Input is refused from the end of a request until its final response word is queued for sending.
- R10: Bytes received outside a packet, without a start marker while idle, are ignored. They cause no response and no access.
- R11: A start marker inside an unfinished packet abandons that packet without a response and begins a new one.
- R12: During reset: out_valid_o, mm_read_o and mm_write_o are low, and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request byte valid |
| in_data_i | input | 8 | Request byte |
| in_sop_i | input | 1 | First byte of a request packet |
| in_eop_i | input | 1 | Last byte of a request packet |
| in_ready_o | output | 1 | Engine accepts a request byte |
| out_valid_o | output | 1 | Response byte valid |
| out_data_o | output | 8 | Response byte |
| out_sop_o | output | 1 | First byte of a response packet |
| out_eop_o | output | 1 | Last byte of a response packet |
| out_ready_i | input | 1 | Downstream accepts a response byte |
| mm_address_o | output | 32 | Byte address of the access |
| mm_read_o | output | 1 | Read access request |
| mm_write_o | output | 1 | Write access request |
| mm_writedata_o | output | 32 | Write data |
| mm_readdata_i | input | 32 | Read data, valid in the cycle the read is accepted |
| mm_waitrequest_i | input | 1 | Slave stalls the current access |

## Verification
The hardest case to reach is an access stalled by waitrequest while the response stream is also backpressured. In that case a read word waits for the serializer and the next access must not start early. The bench drives waitrequest and out_ready_i from a free-running pseudo-random sequence, so stalls fall on every phase of multi-word reads and writes. A reference model, built from each request as it is formed, predicts every bus access and every response byte. These are compared on each clock. Malformed packets are sent as well: truncated, too long, headers cut short, bad counts, stray bytes and restarted frames. For these the model expects no access and only the rejection response.

// File: rtl/pkt_mm_pkg.sv
package pkt_mm_pkg;
  localparam logic [7:0] OP_WR     = 8'h00;
  localparam logic [7:0] OP_WR_INC = 8'h04;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_RD_INC = 8'h14;
  localparam logic [7:0] RESP_FLIP = 8'h80;
  localparam int unsigned HDR_BYTES = 8;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] cnt;
    logic [31:0] addr;
    logic        err;
  } req_t;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WR) || (op == OP_WR_INC) || (op == OP_RD) || (op == OP_RD_INC);
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return op[4];
  endfunction

  function automatic logic op_is_inc(input logic [7:0] op);
    return op[2];
  endfunction
endpackage

// File: rtl/pkt_rx_parser.sv
module pkt_rx_parser
  import pkt_mm_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned WIDX = $clog2(MAX_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [7:0]      in_data_i,
  input  logic            in_sop_i,
  input  logic            in_eop_i,
  output logic            in_ready_o,
  output logic            req_valid_o,
  output req_t            req_o,
  input  logic            req_done_i,
  input  logic [WIDX-1:0] rd_idx_i,
  output logic [31:0]     rd_word_o
);
  localparam logic [16:0] MAX_BYTES = 17'(MAX_WORDS * 4);
  localparam logic [16:0] HDR_LEN   = 17'(HDR_BYTES);

  typedef enum logic [1:0] {P_IDLE, P_BODY, P_HOLD} pstate_e;

  pstate_e     state_q;
  logic [16:0] idx_q;
  logic [7:0]  op_q;
  logic [15:0] cnt_q;
  logic [31:0] addr_q;
  logic        err_q;

  logic        accept;
  logic        body_byte;
  logic [16:0] len_c, exp_len_c, doff_c;
  logic        bad_c, data_we;
  logic [WIDX-1:0] word_sel;
  logic [1:0]  lane;
  logic [31:0] words [MAX_WORDS];

  assign in_ready_o = (state_q != P_HOLD);
  assign accept     = in_valid_i && in_ready_o;
  assign body_byte  = accept && !in_sop_i && (state_q == P_BODY);

  assign len_c     = idx_q + 17'd1;
  assign exp_len_c = op_is_read(op_q) ? HDR_LEN : ({1'b0, cnt_q} + HDR_LEN);
  // cnt_q is complete whenever the length can match; short packets fail on length
  assign bad_c = !op_known(op_q) || (cnt_q == 16'd0) || (cnt_q[1:0] != 2'd0) ||
                 ({1'b0, cnt_q} > MAX_BYTES) || (len_c != exp_len_c);

  assign doff_c   = idx_q - HDR_LEN;
  assign data_we  = body_byte && (idx_q >= HDR_LEN) && (doff_c < MAX_BYTES);
  assign word_sel = doff_c[WIDX+1:2];
  assign lane     = doff_c[1:0];

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i) begin
      if (data_we && (word_sel == WIDX'(g))) word_q[8*lane +: 8] <= in_data_i;
    end
    assign words[g] = word_q;
  end

  assign rd_word_o = words[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= P_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept && in_sop_i) begin
        op_q  <= in_data_i;
        idx_q <= 17'd1;
        if (in_eop_i) begin
          state_q <= P_HOLD;
          err_q   <= 1'b1;
        end else begin
          state_q <= P_BODY;
        end
      end else if (body_byte) begin
        if (idx_q != '1) idx_q <= idx_q + 17'd1;
        case (idx_q)
          17'd2:   cnt_q[15:8]   <= in_data_i;
          17'd3:   cnt_q[7:0]    <= in_data_i;
          17'd4:   addr_q[31:24] <= in_data_i;
          17'd5:   addr_q[23:16] <= in_data_i;
          17'd6:   addr_q[15:8]  <= in_data_i;
          17'd7:   addr_q[7:0]   <= in_data_i;
          default: ;
        endcase
        if (in_eop_i) begin
          state_q <= P_HOLD;
          err_q   <= bad_c;
        end
      end else if (state_q == P_HOLD && req_done_i) begin
        state_q <= P_IDLE;
      end
    end
  end

  assign req_valid_o = (state_q == P_HOLD);
  assign req_o = '{op: op_q, cnt: cnt_q, addr: addr_q, err: err_q};

  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_sop_i && !in_eop_i) |=> (state_q == P_BODY && idx_q == 17'd1));
endmodule

// File: rtl/pkt_txn_exec.sv
module pkt_txn_exec
  import pkt_mm_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned WIDX = $clog2(MAX_WORDS),
  localparam int unsigned KW = WIDX + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  req_t            req_i,
  output logic            req_done_o,
  output logic [WIDX-1:0] rd_idx_o,
  input  logic [31:0]     rd_word_i,
  output logic [31:0]     mm_address_o,
  output logic            mm_read_o,
  output logic            mm_write_o,
  output logic [31:0]     mm_writedata_o,
  input  logic [31:0]     mm_readdata_i,
  input  logic            mm_waitrequest_i,
  output logic            word_valid_o,
  output logic [31:0]     word_data_o,
  output logic            word_first_o,
  output logic            word_last_o,
  input  logic            word_ready_i
);
  typedef enum logic [1:0] {X_IDLE, X_BUS, X_SEND} xstate_e;

  xstate_e     state_q;
  logic [31:0] addr_q;
  logic [KW-1:0] k_q;
  logic [31:0] tx_word_q;
  logic        tx_first_q, tx_last_q, final_q;

  logic [KW-1:0] nwords_c;
  logic        last_c, is_rd, bus_go;
  logic [31:0] next_addr_c;

  assign nwords_c    = req_i.cnt[WIDX+2:2];
  assign last_c      = (k_q == nwords_c - KW'(1));
  assign is_rd       = op_is_read(req_i.op);
  assign bus_go      = (state_q == X_BUS) && !mm_waitrequest_i;
  assign next_addr_c = addr_q + (op_is_inc(req_i.op) ? 32'd4 : 32'd0);

  function automatic logic [31:0] ack_word(input logic [7:0] op, input logic [15:0] cnt);
    return {cnt[7:0], cnt[15:8], 8'h00, op ^ RESP_FLIP};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= X_IDLE;
      addr_q     <= '0;
      k_q        <= '0;
      tx_word_q  <= '0;
      tx_first_q <= 1'b0;
      tx_last_q  <= 1'b0;
      final_q    <= 1'b0;
    end else begin
      unique case (state_q)
        X_IDLE: if (req_valid_i) begin
          if (req_i.err) begin
            tx_word_q  <= ack_word(req_i.op, 16'd0);
            tx_first_q <= 1'b1;
            tx_last_q  <= 1'b1;
            final_q    <= 1'b1;
            state_q    <= X_SEND;
          end else begin
            addr_q  <= req_i.addr;
            k_q     <= '0;
            state_q <= X_BUS;
          end
        end
        X_BUS: if (bus_go) begin
          if (is_rd) begin
            tx_word_q  <= mm_readdata_i;
            tx_first_q <= (k_q == '0);
            tx_last_q  <= last_c;
            final_q    <= last_c;
            state_q    <= X_SEND;
          end else if (last_c) begin
            tx_word_q  <= ack_word(req_i.op, req_i.cnt);
            tx_first_q <= 1'b1;
            tx_last_q  <= 1'b1;
            final_q    <= 1'b1;
            state_q    <= X_SEND;
          end else begin
            k_q    <= k_q + KW'(1);
            addr_q <= next_addr_c;
          end
        end
        X_SEND: if (word_ready_i) begin
          if (final_q) begin
            state_q <= X_IDLE;
          end else begin
            k_q     <= k_q + KW'(1);
            addr_q  <= next_addr_c;
            state_q <= X_BUS;
          end
        end
        default: state_q <= X_IDLE;
      endcase
    end
  end

  assign mm_read_o      = (state_q == X_BUS) && is_rd;
  assign mm_write_o     = (state_q == X_BUS) && !is_rd;
  assign mm_address_o   = addr_q;
  assign rd_idx_o       = k_q[WIDX-1:0];
  assign mm_writedata_o = rd_word_i;
  assign word_valid_o   = (state_q == X_SEND);
  assign word_data_o    = tx_word_q;
  assign word_first_o   = tx_first_q;
  assign word_last_o    = tx_last_q;
  assign req_done_o     = (state_q == X_SEND) && word_ready_i && final_q;

  // R7
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mm_read_o || mm_write_o) && mm_waitrequest_i) |=>
      ($stable(mm_address_o) && $stable(mm_read_o) && $stable(mm_write_o) && $stable(mm_writedata_o)));
  // R7
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_read_o && mm_write_o));
  // R3
  addr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_o && !mm_waitrequest_i && req_i.op == OP_WR_INC) |=>
      (!mm_write_o || mm_address_o == $past(mm_address_o) + 32'd4));
  // R3
  addr_fix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_o && !mm_waitrequest_i && req_i.op == OP_WR) |=>
      (!mm_write_o || mm_address_o == $past(mm_address_o)));
endmodule

// File: rtl/pkt_resp_tx.sv
module pkt_resp_tx (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        word_valid_i,
  input  logic [31:0] word_data_i,
  input  logic        word_first_i,
  input  logic        word_last_i,
  output logic        word_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  input  logic        out_ready_i
);
  logic [31:0] shreg_q;
  logic [1:0]  lane_q;
  logic        busy_q, first_q, last_q;

  assign word_ready_o = !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      lane_q  <= '0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (!busy_q) begin
      if (word_valid_i) begin
        shreg_q <= word_data_i;
        lane_q  <= '0;
        busy_q  <= 1'b1;
        first_q <= word_first_i;
        last_q  <= word_last_i;
      end
    end else if (out_ready_i) begin
      shreg_q <= {8'h00, shreg_q[31:8]};
      lane_q  <= lane_q + 2'd1;
      if (lane_q == 2'd3) busy_q <= 1'b0;
    end
  end

  assign out_valid_o = busy_q;
  assign out_data_o  = shreg_q[7:0];
  assign out_sop_o   = busy_q && first_q && (lane_q == 2'd0);
  assign out_eop_o   = busy_q && last_q && (lane_q == 2'd3);

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)));
endmodule

// File: rtl/pkt_mm_engine.sv
module pkt_mm_engine
  import pkt_mm_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned WIDX = $clog2(MAX_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_sop_i,
  input  logic        in_eop_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  input  logic        out_ready_i,
  output logic [31:0] mm_address_o,
  output logic        mm_read_o,
  output logic        mm_write_o,
  output logic [31:0] mm_writedata_o,
  input  logic [31:0] mm_readdata_i,
  input  logic        mm_waitrequest_i
);
  req_t            req;
  logic            req_valid, req_done;
  logic [WIDX-1:0] rd_idx;
  logic [31:0]     rd_word;
  logic            word_valid, word_first, word_last, word_ready;
  logic [31:0]     word_data;

  pkt_rx_parser #(.MAX_WORDS(MAX_WORDS)) u_parser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .in_ready_o  (in_ready_o),
    .req_valid_o (req_valid),
    .req_o       (req),
    .req_done_i  (req_done),
    .rd_idx_i    (rd_idx),
    .rd_word_o   (rd_word)
  );

  pkt_txn_exec #(.MAX_WORDS(MAX_WORDS)) u_exec (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid),
    .req_i            (req),
    .req_done_o       (req_done),
    .rd_idx_o         (rd_idx),
    .rd_word_i        (rd_word),
    .mm_address_o     (mm_address_o),
    .mm_read_o        (mm_read_o),
    .mm_write_o       (mm_write_o),
    .mm_writedata_o   (mm_writedata_o),
    .mm_readdata_i    (mm_readdata_i),
    .mm_waitrequest_i (mm_waitrequest_i),
    .word_valid_o     (word_valid),
    .word_data_o      (word_data),
    .word_first_o     (word_first),
    .word_last_o      (word_last),
    .word_ready_i     (word_ready)
  );

  pkt_resp_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid),
    .word_data_i  (word_data),
    .word_first_i (word_first),
    .word_last_i  (word_last),
    .word_ready_o (word_ready),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_sop_o    (out_sop_o),
    .out_eop_o    (out_eop_o),
    .out_ready_i  (out_ready_i)
  );

  // R9
  busy_blocks_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o || mm_write_o) |-> !in_ready_o);
  // R6
  err_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && req.err) |-> !(mm_read_o || mm_write_o));
  // R6
  err_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid && req_valid && req.err) |-> (word_data[31:8] == 24'h0));
endmodule

// File: tb/pkt_mm_engine_tb.sv
`timescale 1ns/1ps
module pkt_mm_engine_tb;
  localparam int unsigned MAX_WORDS = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_sop_i = 1'b0;
  logic        in_eop_i = 1'b0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [7:0]  out_data_o;
  logic        out_sop_o;
  logic        out_eop_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] mm_address_o;
  logic        mm_read_o;
  logic        mm_write_o;
  logic [31:0] mm_writedata_o;
  logic [31:0] mm_readdata_i = '0;
  logic        mm_waitrequest_i = 1'b0;

  pkt_mm_engine #(.MAX_WORDS(MAX_WORDS)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int gapc = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0]  pkt[$];
  logic [9:0]  exp_out[$];
  string       exp_otag[$];
  logic [64:0] exp_bus[$];

  logic        p_act = 1'b0, p_wait = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  logic        p_ov = 1'b0, p_ordy = 1'b0, p_sop = 1'b0, p_eop = 1'b0;
  logic [7:0]  p_odata = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] rdval(input logic [31:0] a);
    return {a[7:0], a[31:8]} ^ 32'h5A3C96E1;
  endfunction

  // per-clock reference comparison, sampled at the falling edge
  always @(negedge clk_i) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mm_waitrequest_i = lfsr[0] & lfsr[3];
    out_ready_i      = !(lfsr[5] & lfsr[7]);
    mm_readdata_i    = rdval(mm_address_o);
    if (!rst_ni) begin
      chk(!out_valid_o && !mm_read_o && !mm_write_o && in_ready_o, "R12 reset state",
          {out_valid_o, mm_read_o, mm_write_o, in_ready_o}, 4'b0001);
      p_act = 1'b0; p_ov = 1'b0;
    end else begin
      if (p_act && p_wait)
        chk(mm_address_o == p_addr && mm_read_o == p_rd && mm_write_o == p_wr && mm_writedata_o == p_wdata,
            "R7 hold under waitrequest", mm_address_o, p_addr);
      chk(!(mm_read_o && mm_write_o), "R7 exclusive", {mm_read_o, mm_write_o}, 0);
      if (p_ov && !p_ordy)
        chk(out_valid_o && out_data_o == p_odata && out_sop_o == p_sop && out_eop_o == p_eop,
            "R8 output hold", {out_valid_o, out_sop_o, out_eop_o, out_data_o}, {1'b1, p_sop, p_eop, p_odata});
      if (mm_read_o || mm_write_o)
        chk(!in_ready_o, "R9 input blocked during access", in_ready_o, 0);
      if ((mm_read_o || mm_write_o) && !mm_waitrequest_i) begin
        if (exp_bus.size() == 0) begin
          chk(0, "R6 unexpected bus access", mm_address_o, 0);
        end else begin
          logic [64:0] e;
          e = exp_bus.pop_front();
          chk(mm_write_o == e[64], "R1 access kind", mm_write_o, e[64]);
          chk(mm_address_o == e[63:32], "R3 access address", mm_address_o, e[63:32]);
          if (e[64]) chk(mm_writedata_o == e[31:0], "R2 write data", mm_writedata_o, e[31:0]);
        end
      end
      if (out_valid_o && out_ready_i) begin
        if (exp_out.size() == 0) begin
          chk(0, "R10 unexpected response byte", out_data_o, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_out.pop_front();
          t = exp_otag.pop_front();
          chk({out_sop_o, out_eop_o, out_data_o} == e, t, {out_sop_o, out_eop_o, out_data_o}, e);
        end
      end
      p_act = mm_read_o || mm_write_o; p_wait = mm_waitrequest_i;
      p_rd = mm_read_o; p_wr = mm_write_o; p_addr = mm_address_o; p_wdata = mm_writedata_o;
      p_ov = out_valid_o; p_ordy = out_ready_i; p_odata = out_data_o;
      p_sop = out_sop_o; p_eop = out_eop_o;
    end
  end

  initial begin
    wait (cyc == 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic exp_byte(input bit s, input bit e, input logic [7:0] b, input string tag);
    exp_out.push_back({s, e, b});
    exp_otag.push_back(tag);
  endtask

  task automatic exp_ack(input logic [7:0] op, input logic [15:0] cnt, input string tag);
    exp_byte(1, 0, op ^ 8'h80, tag);
    exp_byte(0, 0, 8'h00, tag);
    exp_byte(0, 0, cnt[15:8], tag);
    exp_byte(0, 1, cnt[7:0], tag);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [7:0] rsvd, input logic [15:0] cnt, input logic [31:0] a);
    pkt.delete();
    pkt.push_back(op); pkt.push_back(rsvd);
    pkt.push_back(cnt[15:8]); pkt.push_back(cnt[7:0]);
    pkt.push_back(a[31:24]); pkt.push_back(a[23:16]); pkt.push_back(a[15:8]); pkt.push_back(a[7:0]);
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int j = 0; j < 4; j++) pkt.push_back(w[8*j +: 8]);
  endtask

  task automatic send_pkt(input bit with_sop, input bit with_eop);
    for (int i = 0; i < pkt.size(); i++) begin
      @(negedge clk_i);
      gapc++;
      if (gapc % 5 == 3) begin
        in_valid_i = 1'b0;
        @(negedge clk_i);
      end
      in_valid_i = 1'b1;
      in_data_i  = pkt[i];
      in_sop_i   = with_sop && (i == 0);
      in_eop_i   = with_eop && (i == pkt.size() - 1);
      while (!in_ready_o) @(negedge clk_i);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_sop_i = 1'b0;
    in_eop_i = 1'b0;
  endtask

  task automatic req_write(input logic [7:0] op, input logic [7:0] rsvd, input logic [15:0] cnt,
                           input logic [31:0] a, input logic [31:0] seed, input string tag);
    logic [31:0] ad, d;
    hdr(op, rsvd, cnt, a);
    ad = a;
    for (int k = 0; k < cnt / 4; k++) begin
      d = seed + k * 32'h01020304;
      push_word(d);
      exp_bus.push_back({1'b1, ad, d});
      if (op == 8'h04) ad = ad + 4;
    end
    exp_ack(op, cnt, tag);
    send_pkt(1, 1);
  endtask

  task automatic req_read(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] a, input string tag);
    logic [31:0] ad, v;
    int n;
    hdr(op, 8'h00, cnt, a);
    ad = a;
    n = cnt / 4;
    for (int k = 0; k < n; k++) begin
      v = rdval(ad);
      exp_bus.push_back({1'b0, ad, 32'h0});
      for (int j = 0; j < 4; j++) exp_byte(k == 0 && j == 0, k == n - 1 && j == 3, v[8*j +: 8], tag);
      if (op == 8'h14) ad = ad + 4;
    end
    send_pkt(1, 1);
  endtask

  task automatic drain;
    int t;
    t = 0;
    while ((exp_out.size() != 0 || exp_bus.size() != 0) && t < 2000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (4) @(negedge clk_i);
    chk(exp_out.size() == 0, "R5 response complete", exp_out.size(), 0);
    chk(exp_bus.size() == 0, "R3 all accesses made", exp_bus.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && in_ready_o, "R12 after reset", {out_valid_o, in_ready_o}, 2'b01);

    // R1 R2 R4: single write, value 0x5f03ff4a at 0x024b7a40
    hdr(8'h00, 8'h00, 16'd4, 32'h024b7a40);
    pkt.push_back(8'h4a); pkt.push_back(8'hff); pkt.push_back(8'h03); pkt.push_back(8'h5f);
    exp_bus.push_back({1'b1, 32'h024b7a40, 32'h5f03ff4a});
    exp_ack(8'h00, 16'd4, "R4 single write ack");
    send_pkt(1, 1);
    drain();

    req_write(8'h04, 8'h00, 16'd12, 32'h0000_1000, 32'h1111_0000, "R3 incrementing write ack");
    req_write(8'h00, 8'hAB, 16'd8,  32'h0000_2000, 32'h2222_0000, "R1 reserved ignored R4 ack");
    req_read(8'h10, 16'd4,  32'h024b3a40, "R5 single read");
    req_read(8'h14, 16'd16, 32'h0000_3000, "R5 incrementing read");
    req_read(8'h10, 16'd8,  32'h0000_4004, "R3 fixed-address read R5");
    req_write(8'h04, 8'h00, 16'(MAX_WORDS * 4), 32'h0000_5000, 32'h3333_0000, "R4 max-size write ack");
    drain();

    // R6 rejections
    hdr(8'h08, 8'h00, 16'd4, 32'h100); push_word(32'h1);
    exp_ack(8'h08, 16'd0, "R6 unknown opcode"); send_pkt(1, 1);
    hdr(8'h10, 8'h00, 16'd6, 32'h100);
    exp_ack(8'h10, 16'd0, "R6 count not multiple of 4"); send_pkt(1, 1);
    hdr(8'h14, 8'h00, 16'd0, 32'h100);
    exp_ack(8'h14, 16'd0, "R6 zero count"); send_pkt(1, 1);
    hdr(8'h14, 8'h00, 16'(MAX_WORDS * 4 + 4), 32'h100);
    exp_ack(8'h14, 16'd0, "R6 count above limit"); send_pkt(1, 1);
    hdr(8'h04, 8'h00, 16'd8, 32'h100); push_word(32'hDEAD_BEEF);
    exp_ack(8'h04, 16'd0, "R6 truncated write data"); send_pkt(1, 1);
    hdr(8'h00, 8'h00, 16'd4, 32'h100); push_word(32'h2); pkt.push_back(8'h77);
    exp_ack(8'h00, 16'd0, "R6 write too long"); send_pkt(1, 1);
    hdr(8'h10, 8'h00, 16'd4, 32'h100); pkt.push_back(8'h00);
    exp_ack(8'h10, 16'd0, "R6 read too long"); send_pkt(1, 1);
    hdr(8'h10, 8'h00, 16'd4, 32'h100); void'(pkt.pop_back()); void'(pkt.pop_back()); void'(pkt.pop_back());
    exp_ack(8'h10, 16'd0, "R6 header cut short"); send_pkt(1, 1);
    pkt.delete(); pkt.push_back(8'h00);
    exp_ack(8'h00, 16'd0, "R6 one-byte packet"); send_pkt(1, 1);
    drain();

    // R10 stray bytes while idle
    pkt.delete(); pkt.push_back(8'h00); pkt.push_back(8'h10); pkt.push_back(8'h7b);
    send_pkt(0, 1);
    repeat (20) @(negedge clk_i);
    chk(!out_valid_o, "R10 no response to stray bytes", out_valid_o, 0);
    req_read(8'h10, 16'd4, 32'h0000_6000, "R10 read after stray bytes");
    drain();

    // R11 restart inside an unfinished packet
    hdr(8'h00, 8'h00, 16'd4, 32'h0000_7000);
    send_pkt(1, 0);
    repeat (20) @(negedge clk_i);
    chk(!out_valid_o && !mm_write_o, "R11 abandoned packet silent", {out_valid_o, mm_write_o}, 0);
    req_write(8'h04, 8'h00, 16'd8, 32'h0000_8000, 32'h4444_0000, "R11 write after restart");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule